// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Emulator

This block is a synchronous slave that imitates a small serial EEPROM reached over chip select, serial clock, data in and data out. A register array holds the stored words. Commands are shifted in most-significant bit first on rising serial-clock edges. The block supports read, single-word write, erase-all, write-all, write-enable and write-disable.

All pins are sampled by the system clock through a two-stage synchronizer, so the serial clock must be much slower than the system clock. A modifying command is accepted on the falling edge of chip select. That edge starts a self-timed program cycle, which runs on an internal counter and needs no further serial-clock pulses. Each operation has its own duration, given as a parameter in system-clock cycles. If chip select is raised while the cycle runs, data out reports busy or ready.

`DEPTH` must be a power of two. `WORD_W` is 16 or 8.

Top module: `mw_eeprom`

## Requirements
- R1: After reset the block is write-disabled and not busy, every stored bit is 1, and `dout_oe` is 0.
- R2: A frame has the following parts, all sampled on rising `sclk` edges while `cs` is high:
  - Zeros before the first 1 are ignored, and that first 1 is the start bit.
  - A 2-bit opcode follows: `10` is read, `01` is write, `00` is a control command and `11` is ignored.
  - `ADDR_W` address bits follow, MSB first.
  - For opcode `00`, the two top address bits select the command: `11` enable, `00` disable, `10` erase-all, `01` write-all.
- R3: After the last address bit of a read, `dout_oe` is 1 and `dout` shows the addressed word MSB first. Each later rising `sclk` edge moves to the next bit.
- R4: A write takes `WORD_W` data bits MSB first. The program cycle starts at the fall of `cs`. After it, the addressed word holds the data and every other word is unchanged.
- R5: Erase-all sets every bit of the array to 1 and keeps the block busy for `T_ERAL` cycles.
- R6: Write-all stores its data word in every location and keeps the block busy for `T_WRAL` cycles. It works whatever the earlier contents were.
- R7: While the block is write-disabled, a write, erase-all or write-all is dropped. No cycle starts and the array keeps its contents. A disable command returns the block to that state after it was enabled.
- R8: If a rising `sclk` edge arrives after the last bit of a non-read command and before `cs` falls, that command is discarded.
- R9: If `cs` rises during a program cycle after being low for at least `CSL_MIN` cycles, `dout_oe` goes to 1. `dout` then shows 0 while busy and 1 once done. The time from the fall of `cs` to ready is between T and T+10 cycles, where T is the operation's duration (`T_WRITE` for a write).
- R10: Any command shifted in during a program cycle is ignored and does not change the array.
- R11: `dout_oe` is 0 whenever `cs` is low, and also while `cs` is high with no read or status being presented. This includes a `cs` rise that follows a low time shorter than `CSL_MIN`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs | input | 1 | Chip select, active high |
| sclk | input | 1 | Serial clock; bits are taken on its rising edge |
| di | input | 1 | Serial data in |
| dout | output | 1 | Serial data out: read data or ready/busy status |
| dout_oe | output | 1 | Drive enable for `dout`; 0 means high impedance |

## Verification
Reads are run before and after each modifying operation:
- The initial all-ones state separates a real write from a dropped one.
- Write-all with an alternating pattern separates write-all from erase-all.
- Checking the next address after a write shows that other words are untouched.

Each enabled operation is timed through the status output. The three durations differ, so this also shows that the right operation was decoded. The following patterns are each expected to leave the array unchanged:
- an extra clock bit after a frame;
- a frame sent while the block is busy;
- a write sent while the block is disabled.

Leading zeros before the start bit are checked, and so is a short chip-select low time that must not arm the status output.

// File: rtl/mw_pkg.sv
package mw_pkg;

  typedef enum logic [2:0] {
    CMD_NONE, CMD_READ, CMD_WRITE, CMD_ERAL, CMD_WRAL, CMD_EWEN, CMD_EWDS
  } cmd_e;

  // Opcode plus the two top address bits select the command.
  function automatic cmd_e decode_cmd(input logic [1:0] op, input logic [1:0] sub);
    case (op)
      2'b10: return CMD_READ;
      2'b01: return CMD_WRITE;
      2'b00: begin
        case (sub)
          2'b11: return CMD_EWEN;
          2'b00: return CMD_EWDS;
          2'b10: return CMD_ERAL;
          default: return CMD_WRAL;
        endcase
      end
      default: return CMD_NONE;
    endcase
  endfunction

  function automatic logic needs_data(input cmd_e c);
    return (c == CMD_WRITE) || (c == CMD_WRAL);
  endfunction

  function automatic logic modifies(input cmd_e c);
    return (c == CMD_WRITE) || (c == CMD_ERAL) || (c == CMD_WRAL);
  endfunction

endpackage

// File: rtl/mw_sync.sv
module mw_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] a,
  output logic [W-1:0] s,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);
  logic [STAGES-1:0][W-1:0] pipe;
  logic [W-1:0]             prev;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) pipe <= '0;
        else        pipe <= a;
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) pipe <= '0;
        else        pipe <= {pipe[STAGES-2:0], a};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev <= '0;
    else        prev <= pipe[STAGES-1];

  assign s    = pipe[STAGES-1];
  assign rise = s & ~prev;
  assign fall = ~s & prev;
endmodule

// File: rtl/mw_cmd_shift.sv
module mw_cmd_shift
  import mw_pkg::*;
#(
  parameter int AW = 4,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_s,
  input  logic          sclk_rise,
  input  logic          di_s,
  input  logic          hold,
  output logic          started,
  output logic          hdr_done,
  output logic          complete,
  output logic          overrun,
  output cmd_e          cmd,
  output logic [AW-1:0] addr,
  output logic [DW-1:0] data
);
  localparam int HDR = 2 + AW;
  localparam int CW  = $clog2(HDR + DW + 1);

  logic [HDR-1:0] hdr, hdr_nx;
  logic [CW-1:0]  cnt;
  cmd_e           dec;

  assign hdr_nx = {hdr[HDR-2:0], di_s};
  assign dec    = decode_cmd(hdr_nx[HDR-1 -: 2], hdr_nx[AW-1 -: 2]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      started <= 1'b0; complete <= 1'b0; overrun <= 1'b0; hdr_done <= 1'b0;
      cnt <= '0; hdr <= '0; data <= '0; addr <= '0; cmd <= CMD_NONE;
    end else begin
      hdr_done <= 1'b0;
      if (!cs_s) begin
        started <= 1'b0; complete <= 1'b0; overrun <= 1'b0;
        cnt <= '0; cmd <= CMD_NONE;
      end else if (sclk_rise && !hold) begin
        if (!started) begin
          started <= di_s;                 // leading zeros skipped
        end else if (!complete) begin
          cnt <= cnt + 1'b1;
          if (cnt < CW'(HDR)) hdr <= hdr_nx;
          else                data <= {data[DW-2:0], di_s};
          if (cnt == CW'(HDR - 1)) begin
            cmd      <= dec;
            addr     <= hdr_nx[AW-1:0];
            hdr_done <= 1'b1;
            if (!needs_data(dec)) complete <= 1'b1;
          end else if (cnt == CW'(HDR + DW - 1)) begin
            complete <= 1'b1;
          end
        end else if (cmd != CMD_READ) begin
          overrun <= 1'b1;                 // clock after last bit voids frame
        end
      end
    end
  end

  assert_complete_needs_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    complete |-> started);
  assert_overrun_after_complete_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> $past(complete));
endmodule

// File: rtl/mw_prog_timer.sv
module mw_prog_timer
  import mw_pkg::*;
#(
  parameter int T_WRITE = 200,
  parameter int T_ERAL  = 400,
  parameter int T_WRAL  = 800
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  cmd_e cmd,
  output logic busy,
  output logic done
);
  localparam int TMAX = (T_WRAL > T_ERAL) ? ((T_WRAL > T_WRITE) ? T_WRAL : T_WRITE)
                                          : ((T_ERAL > T_WRITE) ? T_ERAL : T_WRITE);
  localparam int CW = $clog2(TMAX + 1);

  logic [CW-1:0] cnt;

  function automatic logic [CW-1:0] cycles_for(input cmd_e c);
    case (c)
      CMD_ERAL: return CW'(T_ERAL);
      CMD_WRAL: return CW'(T_WRAL);
      default:  return CW'(T_WRITE);
    endcase
  endfunction

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)          cnt <= '0;
    else if (start)      cnt <= cycles_for(cmd);
    else if (cnt != '0)  cnt <= cnt - 1'b1;

  assign busy = (cnt != '0);
  assign done = (cnt == CW'(1));

  assert_busy_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);
  assert_done_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);
  assert_start_rises_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy);
endmodule

// File: rtl/mw_eeprom.sv
module mw_eeprom
  import mw_pkg::*;
#(
  parameter int DEPTH   = 16,
  parameter int WORD_W  = 16,
  parameter int T_WRITE = 200,
  parameter int T_ERAL  = 400,
  parameter int T_WRAL  = 800,
  parameter int CSL_MIN = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs,
  input  logic sclk,
  input  logic di,
  output logic dout,
  output logic dout_oe
);
  localparam int ADDR_W = $clog2(DEPTH);
  localparam int LW     = $clog2(CSL_MIN + 2);

  // synchronized pins and events
  logic [2:0] pin_s, pin_rise, pin_fall;
  logic cs_s, cs_rise, cs_fall, sclk_rise, di_s;

  mw_sync #(.W(3), .STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .a({cs, sclk, di}),
    .s(pin_s), .rise(pin_rise), .fall(pin_fall));

  assign cs_s      = pin_s[2];
  assign cs_rise   = pin_rise[2];
  assign cs_fall   = pin_fall[2];
  assign sclk_rise = pin_rise[1];
  assign di_s      = pin_s[0];

  // command shifter
  logic              sh_started, sh_hdr_done, sh_complete, sh_overrun;
  cmd_e              sh_cmd;
  logic [ADDR_W-1:0] sh_addr;
  logic [WORD_W-1:0] sh_data;
  logic              busy, prog_done;

  mw_cmd_shift #(.AW(ADDR_W), .DW(WORD_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .cs_s(cs_s), .sclk_rise(sclk_rise), .di_s(di_s),
    .hold(busy), .started(sh_started), .hdr_done(sh_hdr_done),
    .complete(sh_complete), .overrun(sh_overrun), .cmd(sh_cmd),
    .addr(sh_addr), .data(sh_data));

  // named events
  logic cmd_accept, prog_start;
  logic wen;
  assign cmd_accept = cs_fall && sh_complete && !sh_overrun && !busy;
  assign prog_start = cmd_accept && modifies(sh_cmd) && wen;

  mw_prog_timer #(.T_WRITE(T_WRITE), .T_ERAL(T_ERAL), .T_WRAL(T_WRAL)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(prog_start), .cmd(sh_cmd),
    .busy(busy), .done(prog_done));

  // write enable latch
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) wen <= 1'b0;
    else if (cmd_accept && sh_cmd == CMD_EWEN) wen <= 1'b1;
    else if (cmd_accept && sh_cmd == CMD_EWDS) wen <= 1'b0;

  // pending operation and storage array
  cmd_e                           p_cmd;
  logic [ADDR_W-1:0]              p_addr;
  logic [WORD_W-1:0]              p_data;
  logic [DEPTH-1:0][WORD_W-1:0]   mem;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      p_cmd <= CMD_NONE; p_addr <= '0; p_data <= '0;
    end else if (prog_start) begin
      p_cmd <= sh_cmd; p_addr <= sh_addr; p_data <= sh_data;
    end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem <= '1;
    end else if (prog_done) begin
      case (p_cmd)
        CMD_WRITE: mem[p_addr] <= p_data;
        CMD_ERAL:  mem <= '1;
        CMD_WRAL:  for (int i = 0; i < DEPTH; i++) mem[i] <= p_data;
        default:   ;
      endcase
    end
  end

  // status arming after a long enough low phase
  logic [LW-1:0] low_cnt;
  logic          armed;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                   low_cnt <= '0;
    else if (cs_s)                low_cnt <= '0;
    else if (low_cnt != {LW{1'b1}}) low_cnt <= low_cnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        armed <= 1'b0;
    else if (cs_fall)  armed <= 1'b0;
    else if (cs_rise && busy && low_cnt >= LW'(CSL_MIN)) armed <= 1'b1;
    else if (sh_started) armed <= 1'b0;

  // read shifter
  logic              rd_active;
  logic [WORD_W-1:0] rd_sh;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rd_active <= 1'b0; rd_sh <= '1;
    end else if (!cs_s) begin
      rd_active <= 1'b0;
    end else if (sh_hdr_done && sh_cmd == CMD_READ) begin
      rd_active <= 1'b1; rd_sh <= mem[sh_addr];
    end else if (sclk_rise && rd_active) begin
      rd_sh <= {rd_sh[WORD_W-2:0], 1'b1};
    end

  // output stage
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      dout <= 1'b0; dout_oe <= 1'b0;
    end else begin
      dout_oe <= cs_s && (armed || rd_active);
      dout    <= armed ? !busy : rd_sh[WORD_W-1];
    end

  assert_oe_off_cs_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_s |=> !dout_oe);
  assert_start_needs_wen_R7: assert property (@(posedge clk) disable iff (!rst_n)
    prog_start |-> wen);
  assert_no_start_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    prog_start |-> !busy);
  assert_array_only_on_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !prog_done |=> $stable(mem));
  assert_status_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && cs_s && $past(armed) && !busy) |=> dout);
endmodule

// File: tb/test_mw_eeprom.sv
module test_mw_eeprom;
  localparam int DEPTH = 16, DW = 16, AW = 4;
  localparam int TW = 200, TE = 400, TA = 800, CSL = 50;

  logic clk = 1'b0, rst_n = 1'b0, cs = 1'b0, sclk = 1'b0, di = 1'b0;
  logic dout, dout_oe;
  int   cyc = 0, checks = 0, failures = 0;
  bit   finished = 1'b0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  mw_eeprom #(.DEPTH(DEPTH), .WORD_W(DW), .T_WRITE(TW), .T_ERAL(TE),
              .T_WRAL(TA), .CSL_MIN(CSL)) i_mw_eeprom (
    .clk(clk), .rst_n(rst_n), .cs(cs), .sclk(sclk), .di(di),
    .dout(dout), .dout_oe(dout_oe));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic waitn(input int n); repeat (n) @(negedge clk); endtask

  task automatic sbit(input logic b);
    di = b; waitn(4); sclk = 1'b1; waitn(8); sclk = 1'b0; waitn(4);
  endtask

  task automatic send(input logic [31:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) sbit(v[i]);
  endtask

  // start bit, opcode, address, optional data; cs left high
  task automatic frame(input logic [1:0] op, input logic [AW-1:0] a,
                       input logic [DW-1:0] d, input bit with_data);
    cs = 1'b1; waitn(6);
    sbit(1'b1); send(op, 2); send(a, AW);
    if (with_data) send(d, DW);
  endtask

  task automatic cs_low(input int n); cs = 1'b0; waitn(n); endtask

  task automatic read_word(input logic [AW-1:0] a, input int lead, input string req,
                           input logic [DW-1:0] exp);
    logic [DW-1:0] got;
    logic          oe_ok = 1'b1;
    cs = 1'b1; waitn(6);
    send(0, lead); sbit(1'b1); send(2'b10, 2); send(a, AW);
    waitn(2);
    for (int i = DW - 1; i >= 0; i--) begin
      got[i] = dout;
      if (dout_oe !== 1'b1) oe_ok = 1'b0;
      if (i > 0) sbit(1'b0);
    end
    chk({req, " read data"}, got, exp);
    chk({req, " oe during read (R3)"}, oe_ok, 1'b1);
    cs_low(20);
  endtask

  // status timing: cs low CSL+10 cycles, then poll for ready
  task automatic timed_cycle(input int t, input string req);
    int t0, d;
    cs = 1'b0; t0 = cyc; waitn(CSL + 10);
    cs = 1'b1; waitn(6);
    chk({req, " status busy oe (R9)"}, {dout_oe, dout}, 2'b10);
    while (dout !== 1'b1 && (cyc - t0) < t + 100) waitn(1);
    d = cyc - t0;
    chk({req, " duration in window (R9)"}, (d >= t && d <= t + 10), 1'b1);
    chk({req, " ready oe (R9)"}, {dout_oe, dout}, 2'b11);
    cs_low(20);
  endtask

  task automatic t_reset;
    waitn(2);
    chk("R1 oe after reset", dout_oe, 1'b0);
    read_word(4'd0, 0, "R1 erased word 0", 16'hFFFF);
    cs = 1'b1; waitn(10);
    chk("R11 oe idle cs high", dout_oe, 1'b0);
    cs_low(20);
    chk("R11 oe with cs low", dout_oe, 1'b0);
  endtask

  task automatic t_disabled_write;
    frame(2'b01, 4'd2, 16'h1234, 1);
    cs_low(CSL + 10); cs = 1'b1; waitn(6);
    chk("R7 no status when disabled", dout_oe, 1'b0);
    cs_low(TW + 50);
    read_word(4'd2, 0, "R7 disabled write dropped", 16'hFFFF);
  endtask

  task automatic t_enable_write;
    frame(2'b00, 4'b1100, '0, 0); cs_low(20);
    frame(2'b01, 4'd2, 16'hA5C3, 1);
    timed_cycle(TW, "R4 write");
    read_word(4'd2, 0, "R4 written word", 16'hA5C3);
    read_word(4'd3, 0, "R4 neighbour untouched", 16'hFFFF);
  endtask

  task automatic t_short_low;
    frame(2'b01, 4'd4, 16'h0F0F, 1);
    cs_low(10); cs = 1'b1; waitn(6);
    chk("R11 short low gives no status (R9)", dout_oe, 1'b0);
    cs_low(TW + 50);
    read_word(4'd4, 0, "R4 write after short low", 16'h0F0F);
  endtask

  task automatic t_overrun;
    frame(2'b01, 4'd6, 16'h3C3C, 1);
    sbit(1'b0);
    cs_low(TW + 50);
    read_word(4'd6, 0, "R8 overrun frame discarded", 16'hFFFF);
  endtask

  task automatic t_busy_ignore;
    frame(2'b01, 4'd7, 16'h1111, 1);
    cs_low(CSL + 10);
    frame(2'b01, 4'd8, 16'h2222, 1);
    cs_low(TW + 100);
    read_word(4'd8, 0, "R10 command during busy ignored", 16'hFFFF);
    read_word(4'd7, 0, "R10 first write kept", 16'h1111);
  endtask

  task automatic t_wral_eral;
    frame(2'b00, 4'b0100, 16'h5A5A, 1);
    timed_cycle(TA, "R6 write-all");
    read_word(4'd0,  0, "R6 word 0 filled", 16'h5A5A);
    read_word(4'd15, 2, "R6 word 15 filled, leading zeros (R2)", 16'h5A5A);
    frame(2'b00, 4'b1000, '0, 0);
    timed_cycle(TE, "R5 erase-all");
    read_word(4'd9, 0, "R5 erased word 9", 16'hFFFF);
    read_word(4'd7, 0, "R5 erased word 7", 16'hFFFF);
  endtask

  task automatic t_disable_again;
    frame(2'b00, 4'b0000, '0, 0); cs_low(20);
    frame(2'b00, 4'b0100, 16'h0000, 1);
    cs_low(TA + 50);
    read_word(4'd1, 0, "R7 write-all after disable dropped", 16'hFFFF);
    frame(2'b11, 4'd1, '0, 0); cs = 1'b1; waitn(10);
    chk("R2 unused opcode gives no output", dout_oe, 1'b0);
    cs_low(20);
  endtask

  initial begin : watchdog
    waitn(150000);
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    waitn(5); rst_n = 1'b1; waitn(5);
    t_reset();
    t_disabled_write();
    t_enable_write();
    t_short_low();
    t_overrun();
    t_busy_ignore();
    t_wral_eral();
    t_disable_again();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule